// File: doc/BRIEF.md
# Three-Wire SAR Converter Read Sequencer

This block sits on the host side of a single 14-bit successive-approximation converter that shares one line for starting a conversion and selecting the device. On a start request it raises that line. It keeps the line high for a programmable number of system clock cycles so that the converter finishes without raising its busy indication. It then lowers the line, and this puts the most significant result bit on the converter's serial output. After a programmable enable delay the block takes that first bit. It then produces one fewer serial clock pulse than there are data bits and takes one more bit after each falling edge.

All timing is set in system clock cycles through input ports: conversion time, enable delay, half period of the serial clock, and minimum spacing between conversion starts. The assembled word is presented with a one-cycle valid pulse. A busy flag covers the whole transaction. Start requests that arrive while a transaction runs, or before the spacing time has run out, are dropped. A zero on any timing input is treated as one.

Top module: `sar3w_host`

## Requirements
- R1: After reset, the convert line, serial clock, busy flag and valid pulse are all low and the sample word is zero.
- R2: A start request seen in an idle cycle, with the spacing time elapsed, raises the convert line and the busy flag on the next clock edge.
- R3: The convert line stays high for exactly `conv_cycles` system clock cycles and then goes low.
- R4: The serial clock is low whenever the convert line is high or the block is idle. Its first rising edge comes exactly `enable_delay` cycles after the convert line falls, and the first (most significant) data bit is taken on that same clock edge.
- R5: Each transaction produces exactly DATA_W-1 serial clock pulses. Each pulse is high for `half_period` cycles and is followed by `half_period` low cycles.
- R6: After each serial clock falling edge, the data line is sampled at the end of the following low phase. The word is assembled most significant bit first, so the bit taken first lands in bit DATA_W-1 and the last in bit 0.
- R7: When the last bit is taken, `sample_valid` is high for exactly one cycle, carrying the finished word. In that same cycle `busy` goes low.
- R8: A start request is ignored while busy. It is also ignored until `cycle_time` cycles have passed since the last accepted start. When start is held high, consecutive convert rises are spaced by the larger of `cycle_time` and the transaction length plus one.
- R9: `sample_word` keeps its value in every cycle without a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request for one conversion and read |
| conv_cycles | input | TW | Cycles the convert line is held high |
| enable_delay | input | TW | Cycles from convert fall to first bit sample |
| half_period | input | TW | Serial clock high time and low time, in cycles |
| cycle_time | input | TW | Minimum cycles between accepted starts |
| sdi | input | 1 | Serial data from the converter |
| cnv | output | 1 | Convert start and device select line |
| sck | output | 1 | Serial clock, idles low |
| busy | output | 1 | High from accepted start until the word is delivered |
| sample_valid | output | 1 | One-cycle pulse marking a new word |
| sample_word | output | DATA_W | Assembled conversion result |

## Verification
On every cycle the assertions check these properties: the length of the convert pulse, the serial clock staying quiet while converting or idle, the count of clock pulses at delivery, the single-cycle valid with busy dropping, word stability, and the minimum spacing between convert rises. Bit ordering and sampling phase can only be shown by the bench scenarios. The bench drives a behavioural converter model that shifts on serial clock falling edges and compares the delivered word against the value the model was given. Those scenarios also measure the enable delay and the high and low widths of the clock across a sweep of timing settings.

// File: rtl/sar3w_pkg.sv
package sar3w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_ENWT  = 2'd2,
    ST_SHIFT = 2'd3
  } sar3w_state_t;
endpackage

// File: rtl/sar3w_gate.sv
// Spacing timer: blocks new starts until cycle_time cycles after the last one.
module sar3w_gate #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [TW-1:0] cycle_time,
  output logic          ready
);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (accept) begin
      left_q <= (cycle_time == '0) ? '0 : cycle_time - 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign ready = (left_q == '0);
endmodule

// File: rtl/sar3w_sck_gen.sv
// Serial clock pulse train: NPULSE pulses, high then low for half_period each.
module sar3w_sck_gen #(
  parameter int TW     = 16,
  parameter int NPULSE = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [TW-1:0] half_period,
  output logic          sck,
  output logic          sample_stb,
  output logic          last_stb
);
  localparam int PCW = $clog2(NPULSE + 1);

  logic [TW-1:0]  ph_q;
  logic [PCW-1:0] left_q;
  logic           sck_q;
  logic           act_q;
  logic [TW-1:0]  ph_load;
  logic           low_end;

  assign ph_load = (half_period == '0) ? '0 : half_period - 1'b1;
  assign low_end = act_q && !sck_q && (ph_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      left_q <= '0;
      sck_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (launch) begin
      ph_q   <= ph_load;
      left_q <= PCW'(NPULSE);
      sck_q  <= 1'b1;
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (ph_q != '0) begin
        ph_q <= ph_q - 1'b1;
      end else if (sck_q) begin
        sck_q <= 1'b0;
        ph_q  <= ph_load;
      end else if (left_q == PCW'(1)) begin
        act_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        sck_q  <= 1'b1;
        ph_q   <= ph_load;
      end
    end
  end

  assign sck        = sck_q;
  assign sample_stb = low_end;
  assign last_stb   = low_end && (left_q == PCW'(1));
endmodule

// File: rtl/sar3w_capture.sv
// Shift register filling MSB first, with a registered output word.
module sar3w_capture #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              finish,
  input  logic              sdi,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {sh_q[DATA_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      if (shift_en) sh_q <= sh_next;
      if (finish)   word_q <= sh_next;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/sar3w_host.sv
module sar3w_host
  import sar3w_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TW-1:0]     conv_cycles,
  input  logic [TW-1:0]     enable_delay,
  input  logic [TW-1:0]     half_period,
  input  logic [TW-1:0]     cycle_time,
  input  logic              sdi,
  output logic              cnv,
  output logic              sck,
  output logic              busy,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_word
);
  localparam int NPULSE = DATA_W - 1;

  sar3w_state_t  state_q;
  logic [TW-1:0] tcnt_q;
  logic          cnv_q;
  logic          busy_q;
  logic          valid_q;
  logic          ready;
  logic          accept;
  logic          launch;
  logic          sample_stb;
  logic          last_stb;

  assign accept = (state_q == ST_IDLE) && start && ready;
  assign launch = (state_q == ST_ENWT) && (tcnt_q == '0);

  sar3w_gate #(.TW(TW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .cycle_time (cycle_time),
    .ready      (ready)
  );

  sar3w_sck_gen #(.TW(TW), .NPULSE(NPULSE)) u_sck (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .half_period (half_period),
    .sck         (sck),
    .sample_stb  (sample_stb),
    .last_stb    (last_stb)
  );

  sar3w_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .shift_en (launch || sample_stb),
    .finish   (last_stb),
    .sdi      (sdi),
    .word     (sample_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      cnv_q   <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_CONV;
            cnv_q   <= 1'b1;
            busy_q  <= 1'b1;
            tcnt_q  <= (conv_cycles == '0) ? '0 : conv_cycles - 1'b1;
          end
        end
        ST_CONV: begin
          if (tcnt_q == '0) begin
            state_q <= ST_ENWT;
            cnv_q   <= 1'b0;
            tcnt_q  <= (enable_delay == '0) ? '0 : enable_delay - 1'b1;
          end else begin
            tcnt_q <= tcnt_q - 1'b1;
          end
        end
        ST_ENWT: begin
          if (tcnt_q == '0) state_q <= ST_SHIFT;
          else              tcnt_q  <= tcnt_q - 1'b1;
        end
        ST_SHIFT: begin
          if (last_stb) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            valid_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv          = cnv_q;
  assign busy         = busy_q;
  assign sample_valid = valid_q;
endmodule

// File: rtl/sar3w_host_chk.sv
module sar3w_host_chk #(
  parameter int DATA_W = 14,
  parameter int TW     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [TW-1:0]     conv_cycles,
  input logic [TW-1:0]     cycle_time,
  input logic              cnv,
  input logic              sck,
  input logic              busy,
  input logic              sample_valid,
  input logic [DATA_W-1:0] sample_word
);
  logic          cnv_d, sck_d;
  logic [TW:0]   hi_cnt;
  logic [7:0]    pcnt;
  logic [31:0]   gap;
  logic [TW-1:0] ct_lat;
  logic [TW:0]   conv_exp;

  assign conv_exp = (conv_cycles == '0) ? (TW+1)'(1) : {1'b0, conv_cycles};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_d  <= 1'b0;
      sck_d  <= 1'b0;
      hi_cnt <= '0;
      pcnt   <= '0;
      gap    <= 32'hFFFF_FFFF;
      ct_lat <= '0;
    end else begin
      cnv_d  <= cnv;
      sck_d  <= sck;
      hi_cnt <= cnv ? hi_cnt + 1'b1 : '0;
      if (cnv)                pcnt <= '0;
      else if (sck && !sck_d) pcnt <= pcnt + 1'b1;
      if (cnv && !cnv_d) begin
        gap    <= 32'd1;
        ct_lat <= cycle_time;
      end else if (gap != 32'hFFFF_FFFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  p_rise_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (cnv && !cnv_d) |-> busy);

  p_cnv_width_r3: assert property (@(posedge clk) disable iff (rst)
    (!cnv && cnv_d) |-> (hi_cnt == conv_exp));

  p_sck_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (cnv || !busy) |-> !sck);

  p_pulse_count_r5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (pcnt == 8'(DATA_W - 1)));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  p_valid_busy_r7: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (!busy && $past(busy)));

  p_start_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (cnv && !cnv_d) |-> (gap >= 32'(ct_lat)));

  p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> $stable(sample_word));
endmodule

bind sar3w_host sar3w_host_chk #(.DATA_W(DATA_W), .TW(TW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .conv_cycles  (conv_cycles),
  .cycle_time   (cycle_time),
  .cnv          (cnv),
  .sck          (sck),
  .busy         (busy),
  .sample_valid (sample_valid),
  .sample_word  (sample_word)
);

// File: tb/sar3w_host_bench.sv
module sar3w_host_bench;
  localparam int CLK_P  = 10;
  localparam int DW     = 14;
  localparam int TW     = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [TW-1:0] conv_c = 16'd1, en_c = 16'd1, half_c = 16'd1, cyc_c = 16'd1;
  logic sdi;
  logic cnv, sck, busy, valid;
  logic [DW-1:0] word;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  sar3w_host #(.DATA_W(DW), .TW(TW)) u_sar3w_host (
    .clk(clk), .rst(rst), .start(start),
    .conv_cycles(conv_c), .enable_delay(en_c), .half_period(half_c),
    .cycle_time(cyc_c), .sdi(sdi),
    .cnv(cnv), .sck(sck), .busy(busy),
    .sample_valid(valid), .sample_word(word)
  );

  // Converter model: latch on convert rise, MSB out on convert fall,
  // next bit on every serial clock falling edge.
  logic [DW-1:0] model_val = '0;
  logic [DW-1:0] held = '0;
  int fallcnt = 0;
  always @(posedge cnv or negedge sck) begin
    if (cnv) begin
      held    <= model_val;
      fallcnt <= 0;
    end else begin
      fallcnt <= fallcnt + 1;
    end
  end
  assign sdi = cnv ? 1'b0 : ((fallcnt < DW) ? held[DW-1-fallcnt] : 1'b0);

  // Monitor, away from the active edge
  int cyc = 0, t_rise = -1, t_fall = 0, t_sr = 0, t_sf = 0;
  int hi_len = 0, en_gap = 0, pulses = 0, rises = 0, gap_last = 0;
  int hmin = 0, hmax = 0, lmin = 0, lmax = 0;
  logic first_sck = 1'b0, cnv_d = 1'b0, sck_d = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cnv && !cnv_d) begin
      if (t_rise >= 0) gap_last = cyc - t_rise;
      t_rise = cyc; rises = rises + 1; pulses = 0; first_sck = 1'b1;
      hmin = 1000000; hmax = 0; lmin = 1000000; lmax = 0;
    end
    if (!cnv && cnv_d) begin
      hi_len = cyc - t_rise; t_fall = cyc;
    end
    if (sck && !sck_d) begin
      if (first_sck) begin
        en_gap = cyc - t_fall; first_sck = 1'b0;
      end else begin
        if (cyc - t_sf < lmin) lmin = cyc - t_sf;
        if (cyc - t_sf > lmax) lmax = cyc - t_sf;
      end
      t_sr = cyc; pulses = pulses + 1;
    end
    if (!sck && sck_d) begin
      if (cyc - t_sr < hmin) hmin = cyc - t_sr;
      if (cyc - t_sr > hmax) hmax = cyc - t_sr;
      t_sf = cyc;
    end
    cnv_d = cnv; sck_d = sck;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic run_one(input logic [DW-1:0] v, input int c, input int e, input int h);
    bit got;
    conv_c = TW'(c); en_c = TW'(e); half_c = TW'(h); cyc_c = 16'd1;
    model_val = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_valid(got);
    check(got, "R7 valid seen", int'(got), 1);
    if (got) begin
      check(word == v, "R6 word", int'(word), int'(v));
      check(!busy, "R7 busy low at valid", int'(busy), 0);
      check(hi_len == c, "R3 convert width", hi_len, c);
      check(en_gap == e, "R4 enable delay", en_gap, e);
      check(pulses == DW-1, "R5 pulse count", pulses, DW-1);
      check(hmin == h && hmax == h, "R5 high width", hmax, h);
      check(lmin == h && lmax == h, "R5 low width", lmax, h);
      @(negedge clk);
      check(!valid, "R7 valid single cycle", int'(valid), 0);
      check(word == v, "R9 word held", int'(word), int'(v));
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] lfsr;
    int r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!cnv && !sck && !busy && !valid, "R1 outputs low", int'({cnv, sck, busy, valid}), 0);
    check(word == '0, "R1 word zero", int'(word), 0);
    // R2 start raises convert and busy on next edge
    conv_c = 16'd2; en_c = 16'd1; half_c = 16'd1; cyc_c = 16'd1; model_val = 14'h0123;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(cnv && busy, "R2 convert and busy", int'({cnv, busy}), 3);
    begin
      bit got;
      wait_valid(got);
      check(got && word == 14'h0123, "R6 first word", int'(word), 14'h0123);
    end
    // R6 fixed patterns
    run_one(14'h0000, 2, 1, 1);
    run_one(14'h3FFF, 2, 1, 1);
    run_one(14'h2AAA, 3, 2, 2);
    run_one(14'h1555, 3, 2, 2);
    for (int b = 0; b < DW; b++) run_one(DW'(1) << b, 1, 1, 1);
    // Timing sweep R3 R4 R5 with pseudo-random words
    lfsr = 14'h1ACE;
    for (int h = 1; h <= 3; h++)
      for (int ci = 0; ci < 3; ci++)
        for (int e = 1; e <= 3; e += 2) begin
          lfsr = {lfsr[DW-2:0], lfsr[13] ^ lfsr[12] ^ lfsr[11] ^ lfsr[1]};
          run_one(lfsr, (ci == 0) ? 1 : (ci == 1) ? 2 : 5, e, h);
        end
    // R8 start held while busy: spacing equals transaction length plus one
    conv_c = 16'd2; en_c = 16'd1; half_c = 16'd1; cyc_c = 16'd1;
    repeat (3) @(negedge clk);
    r0 = rises;
    start = 1'b1;
    repeat (65) @(negedge clk);
    start = 1'b0;
    check(gap_last == 2 + 1 + 26 + 1, "R8 busy spacing", gap_last, 30);
    check(rises - r0 == 3, "R8 rises while busy", rises - r0, 3);
    repeat (40) @(negedge clk);
    // R8 cycle_time dominates
    cyc_c = 16'd150;
    r0 = rises;
    start = 1'b1;
    repeat (320) @(negedge clk);
    start = 1'b0;
    check(gap_last == 150, "R8 cycle spacing", gap_last, 150);
    check(rises - r0 == 3, "R8 rises in window", rises - r0, 3);
    repeat (200) @(negedge clk);
    check(!busy && !sck && !cnv, "R4 idle quiet", int'({busy, sck, cnv}), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule